// File: doc/BRIEF.md
# Two-Layer On-Screen-Display Pixel Mixer

This block sits at the pixel-rate end of an on-screen-display engine. Each clock it receives one pixel from each of two character layers. A layer pixel has a foreground dot flag, a color code and a flag saying that the character background is present. The block also receives a 3x3 window of font dots centred on the current pixel. From these it produces one registered output color and an enable that tells the video mixer to show the overlay.

Software sets a single 8-bit control word over a simple write port. That word lands in a shadow register and reaches the datapath only on the next rising edge of vertical sync, so a frame is never drawn with mixed settings. The control word selects these settings:
- global display on or off;
- how the two layers combine: bitwise OR, layer 1 first, or layer 2 first;
- the border style: a full outline, or a shadow that falls right and below;
- whether background areas flash with an external phase input;
- three mode flags (bi-scan, automatic solid space, window), which are passed through to downstream logic.

Top module: `osd_layer_mixer`

## Requirements
- R1: After reset, `pix_en` is 0, `pix_color` equals BLANK_COLOR (default 0), and the three mode outputs are 0. The active configuration is all zeros, so the display is off.
- R2: A write (`cfg_we`=1) loads `cfg_wdata` into the shadow register only. The active configuration copies the shadow on a clock where `vsync` is 1 and was 0 on the previous clock. A write made on that same clock is applied at the following rising edge. Between edges the output follows the old settings.
- R3: The control word bit fields are: [1:0] mixing code, [2] display enable, [3] border style (0 full, 1 shadow), [4] flash enable, [5] bi-scan, [6] solid space, [7] window.
- R4: With display enable 0, `pix_en` is 0 and `pix_color` is BLANK_COLOR whatever the pixel inputs are.
- R5: A layer takes part in a pixel when its dot is set, or when its background flag is set and the background is not being flashed off. Mixing code 00 outputs the bitwise OR of the colors of the layers that take part. Code 11 behaves the same as code 00.
- R6: Mixing code 01 outputs layer 1's color when layer 1 takes part, and otherwise layer 2's color.
- R7: Mixing code 10 outputs layer 2's color when layer 2 takes part, and otherwise layer 1's color.
- R8: `font_win` bit r*3+c holds the dot at row r (0 is the top row) and column c (0 is the left column); bit 4 is the current pixel. With full border style, a pixel is a border pixel when bit 4 is 0 and any of the other 8 bits is 1.
- R9: With shadow border style, a pixel is a border pixel only when bit 4 is 0 and at least one of bits 0, 1 or 3 is 1 (the up-left, up and left neighbours).
- R10: With flash enabled and `flash_phase` 0, background-only layer contributions are dropped. Foreground dots are unaffected. With `flash_phase` 1, or with flash disabled, backgrounds show.
- R11: Output priority is as follows. If any layer dot is set, the output is the mixed color. Otherwise a border pixel outputs BORDER_COLOR (default 4'hF). Otherwise a background-only pixel outputs the mixed color. Otherwise `pix_en` is 0 and the color is BLANK_COLOR.
- R12: `pix_color` and `pix_en` are registered. They reflect the pixel inputs and the active configuration sampled at the previous rising clock edge.
- R13: `mode_biscan`, `mode_solid` and `mode_window` show the active (not shadow) bits 5, 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 8 | Control word write data |
| vsync | input | 1 | Vertical sync; rising edge applies the shadow |
| flash_phase | input | 1 | Flash phase: 1 visible, 0 off |
| l1_dot | input | 1 | Layer 1 foreground dot |
| l1_color | input | COLOR_W | Layer 1 color code |
| l1_bg | input | 1 | Layer 1 background present |
| l2_dot | input | 1 | Layer 2 foreground dot |
| l2_color | input | COLOR_W | Layer 2 color code |
| l2_bg | input | 1 | Layer 2 background present |
| font_win | input | 9 | 3x3 font dot window around the pixel |
| pix_color | output | COLOR_W | Registered output color |
| pix_en | output | 1 | Registered overlay enable |
| mode_biscan | output | 1 | Active bi-scan flag |
| mode_solid | output | 1 | Active solid-space flag |
| mode_window | output | 1 | Active window flag |

## Verification
The assertions rely on `vsync` being low when reset is released, so that the block's edge detector and the property's view of the first edge agree. The priority properties also assume that a layer's color code is stable for the clock it is sampled on. The bench drives every input on the falling clock edge and holds `vsync` low through reset. It raises `vsync` only through a task that gives a single clean high pulse. The bench never changes configuration except through the write port and that pulse, so its model of the active settings stays in step with the block's.

// File: rtl/osd_mix_pkg.sv
package osd_mix_pkg;

  typedef enum logic [1:0] {
    MIX_OR   = 2'b00,
    MIX_L1   = 2'b01,
    MIX_L2   = 2'b10,
    MIX_RSVD = 2'b11
  } mix_e;

  // Field order from msb to lsb: window, solid, biscan, flash, shadow, disp, mix[1:0]
  typedef struct packed {
    logic window_en;
    logic solid_en;
    logic biscan;
    logic flash_en;
    logic shadow_style;
    logic disp_en;
    mix_e mix;
  } osd_cfg_t;

  localparam int CFG_W = $bits(osd_cfg_t);
  localparam int WIN_W = 9;
  localparam int WIN_CENTER = 4;

endpackage

// File: rtl/osd_cfg_regs.sv
module osd_cfg_regs
  import osd_mix_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             vsync,
  output osd_cfg_t         cfg_active
);

  osd_cfg_t shadow_q, shadow_d;
  osd_cfg_t active_q, active_d;
  logic     vsync_q;
  logic     vs_edge;

  assign vs_edge = vsync & ~vsync_q;

  always_comb begin
    shadow_d = shadow_q;
    if (wr_en) shadow_d = osd_cfg_t'(wr_data);
  end

  always_comb begin
    active_d = active_q;
    if (vs_edge) active_d = shadow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
      vsync_q  <= 1'b0;
    end else begin
      shadow_q <= shadow_d;
      active_q <= active_d;
      vsync_q  <= vsync;
    end
  end

  assign cfg_active = active_q;

endmodule

// File: rtl/osd_border_detect.sv
module osd_border_detect
  import osd_mix_pkg::*;
#(
  parameter bit USE_DIAGONALS = 1'b1
) (
  input  logic [WIN_W-1:0] win,
  input  logic             shadow_style,
  output logic             is_border
);

  logic [WIN_W-1:0] full_mask;
  logic [WIN_W-1:0] shadow_mask;

  generate
    if (USE_DIAGONALS) begin : g_diag
      assign full_mask   = 9'h1EF;
      assign shadow_mask = 9'h00B;
    end else begin : g_ortho
      assign full_mask   = 9'h0AA;
      assign shadow_mask = 9'h00A;
    end
  endgenerate

  logic [WIN_W-1:0] sel_mask;
  assign sel_mask  = shadow_style ? shadow_mask : full_mask;
  assign is_border = ~win[WIN_CENTER] & (|(win & sel_mask));

endmodule

// File: rtl/osd_layer_mix.sv
module osd_layer_mix
  import osd_mix_pkg::*;
#(
  parameter int COLOR_W = 4
) (
  input  logic [1:0]         dot,
  input  logic [1:0]         bg,
  input  logic [COLOR_W-1:0] color [2],
  input  logic               bg_hidden,
  input  mix_e               mix,
  output logic               any_dot,
  output logic               any_present,
  output logic [COLOR_W-1:0] mixed
);

  logic [1:0]         present;
  logic [COLOR_W-1:0] val [2];

  for (genvar i = 0; i < 2; i++) begin : g_layer
    assign present[i] = dot[i] | (bg[i] & ~bg_hidden);
    assign val[i]     = present[i] ? color[i] : '0;
  end

  assign any_dot     = |dot;
  assign any_present = |present;

  always_comb begin
    unique case (mix)
      MIX_L1:  mixed = present[0] ? val[0] : val[1];
      MIX_L2:  mixed = present[1] ? val[1] : val[0];
      default: mixed = val[0] | val[1];
    endcase
  end

endmodule

// File: rtl/osd_layer_mixer.sv
module osd_layer_mixer
  import osd_mix_pkg::*;
#(
  parameter int                 COLOR_W      = 4,
  parameter logic [COLOR_W-1:0] BLANK_COLOR  = '0,
  parameter logic [COLOR_W-1:0] BORDER_COLOR = '1,
  parameter bit                 BORDER_DIAG  = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [7:0]         cfg_wdata,
  input  logic               vsync,
  input  logic               flash_phase,
  input  logic               l1_dot,
  input  logic [COLOR_W-1:0] l1_color,
  input  logic               l1_bg,
  input  logic               l2_dot,
  input  logic [COLOR_W-1:0] l2_color,
  input  logic               l2_bg,
  input  logic [8:0]         font_win,
  output logic [COLOR_W-1:0] pix_color,
  output logic               pix_en,
  output logic               mode_biscan,
  output logic               mode_solid,
  output logic               mode_window
);

  osd_cfg_t cfg_act;

  osd_cfg_regs u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_we),
    .wr_data    (cfg_wdata),
    .vsync      (vsync),
    .cfg_active (cfg_act)
  );

  logic is_border;

  osd_border_detect #(.USE_DIAGONALS(BORDER_DIAG)) u_border (
    .win          (font_win),
    .shadow_style (cfg_act.shadow_style),
    .is_border    (is_border)
  );

  logic [COLOR_W-1:0] lay_color [2];
  logic               any_dot, any_present;
  logic [COLOR_W-1:0] mixed;
  logic               bg_hidden;

  assign lay_color[0] = l1_color;
  assign lay_color[1] = l2_color;
  assign bg_hidden    = cfg_act.flash_en & ~flash_phase;

  osd_layer_mix #(.COLOR_W(COLOR_W)) u_mix (
    .dot         ({l2_dot, l1_dot}),
    .bg          ({l2_bg, l1_bg}),
    .color       (lay_color),
    .bg_hidden   (bg_hidden),
    .mix         (cfg_act.mix),
    .any_dot     (any_dot),
    .any_present (any_present),
    .mixed       (mixed)
  );

  logic [COLOR_W-1:0] color_d, color_q;
  logic               en_d, en_q;

  always_comb begin
    color_d = BLANK_COLOR;
    en_d    = 1'b0;
    if (cfg_act.disp_en) begin
      if (any_dot) begin
        color_d = mixed;
        en_d    = 1'b1;
      end else if (is_border) begin
        color_d = BORDER_COLOR;
        en_d    = 1'b1;
      end else if (any_present) begin
        color_d = mixed;
        en_d    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      color_q <= BLANK_COLOR;
      en_q    <= 1'b0;
    end else begin
      color_q <= color_d;
      en_q    <= en_d;
    end
  end

  assign pix_color   = color_q;
  assign pix_en      = en_q;
  assign mode_biscan = cfg_act.biscan;
  assign mode_solid  = cfg_act.solid_en;
  assign mode_window = cfg_act.window_en;

endmodule

// File: rtl/osd_layer_mixer_chk.sv
module osd_layer_mixer_chk
  import osd_mix_pkg::*;
#(
  parameter int                 COLOR_W     = 4,
  parameter logic [COLOR_W-1:0] BLANK_COLOR = '0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               vsync,
  input logic               l1_dot,
  input logic [COLOR_W-1:0] l1_color,
  input logic               l2_dot,
  input logic [COLOR_W-1:0] l2_color,
  input logic [COLOR_W-1:0] pix_color,
  input logic               pix_en,
  input osd_cfg_t           cfg_act
);

  AST_OFF_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_act.disp_en |=> (!pix_en && pix_color == BLANK_COLOR)); // R4

  AST_CFG_HELD_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !(vsync && !$past(vsync)) |=> $stable(cfg_act)); // R2

  AST_DOT_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_act.disp_en && (l1_dot || l2_dot)) |=> pix_en); // R11

  AST_L1_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_act.disp_en && cfg_act.mix == MIX_L1 && l1_dot) |=> pix_color == $past(l1_color)); // R6

  AST_L2_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_act.disp_en && cfg_act.mix == MIX_L2 && l2_dot) |=> pix_color == $past(l2_color)); // R7

endmodule

bind osd_layer_mixer osd_layer_mixer_chk #(
  .COLOR_W     (COLOR_W),
  .BLANK_COLOR (BLANK_COLOR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .vsync     (vsync),
  .l1_dot    (l1_dot),
  .l1_color  (l1_color),
  .l2_dot    (l2_dot),
  .l2_color  (l2_color),
  .pix_color (pix_color),
  .pix_en    (pix_en),
  .cfg_act   (cfg_act)
);

// File: tb/osd_layer_mixer_tb.sv
`timescale 1ns/1ps
module osd_layer_mixer_tb_top;

  localparam logic [3:0] BLANK  = 4'h0;
  localparam logic [3:0] BORDER = 4'hF;

  logic       clk, rst_n;
  logic       cfg_we, vsync, flash_phase;
  logic [7:0] cfg_wdata;
  logic       l1_dot, l1_bg, l2_dot, l2_bg;
  logic [3:0] l1_color, l2_color;
  logic [8:0] font_win;
  logic [3:0] pix_color;
  logic       pix_en, mode_biscan, mode_solid, mode_window;

  osd_layer_mixer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .vsync(vsync), .flash_phase(flash_phase),
    .l1_dot(l1_dot), .l1_color(l1_color), .l1_bg(l1_bg),
    .l2_dot(l2_dot), .l2_color(l2_color), .l2_bg(l2_bg),
    .font_win(font_win), .pix_color(pix_color), .pix_en(pix_en),
    .mode_biscan(mode_biscan), .mode_solid(mode_solid), .mode_window(mode_window)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    logic [3:0] color;
    logic       en;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;
  logic [7:0] m_shadow = 8'h00;
  logic [7:0] m_active = 8'h00;

  // Model from the requirements: bits [1:0] mix, [2] disp, [3] shadow, [4] flash
  function automatic logic [4:0] model(input logic [7:0] c,
      input logic d1, input logic [3:0] c1, input logic b1,
      input logic d2, input logic [3:0] c2, input logic b2,
      input logic [8:0] w, input logic ph);
    logic hid, p1, p2, brd;
    logic [3:0] v1, v2, mx, nb;
    hid = c[4] && !ph;
    p1 = d1 || (b1 && !hid);
    p2 = d2 || (b2 && !hid);
    v1 = p1 ? c1 : 4'h0;
    v2 = p2 ? c2 : 4'h0;
    case (c[1:0])
      2'b01:   mx = p1 ? v1 : v2;
      2'b10:   mx = p2 ? v2 : v1;
      default: mx = v1 | v2;
    endcase
    nb  = 4'(c[3] ? (w[0] | w[1] | w[3])
                  : (w[0] | w[1] | w[2] | w[3] | w[5] | w[6] | w[7] | w[8]));
    brd = !w[4] && nb[0];
    if (!c[2])            return {1'b0, BLANK};
    else if (d1 || d2)    return {1'b1, mx};
    else if (brd)         return {1'b1, BORDER};
    else if (p1 || p2)    return {1'b1, mx};
    else                  return {1'b0, BLANK};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic px(input string tag, input logic d1, input logic [3:0] c1, input logic b1,
      input logic d2, input logic [3:0] c2, input logic b2,
      input logic [8:0] w, input logic ph);
    exp_t e;
    logic [4:0] r;
    @(negedge clk);
    l1_dot = d1; l1_color = c1; l1_bg = b1;
    l2_dot = d2; l2_color = c2; l2_bg = b2;
    font_win = w; flash_phase = ph;
    r = model(m_active, d1, c1, b1, d2, c2, b2, w, ph);
    e.en = r[4]; e.color = r[3:0]; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    m_shadow = v;
  endtask

  task automatic vs_pulse();
    @(negedge clk);
    vsync = 1'b1;
    @(negedge clk);
    vsync = 1'b0;
    m_active = m_shadow;
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.tag, {3'b0, pix_en, pix_color}, {3'b0, e.en, e.color});
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; vsync = 1'b0; flash_phase = 1'b1;
    l1_dot = 0; l1_color = 0; l1_bg = 0; l2_dot = 0; l2_color = 0; l2_bg = 0; font_win = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 pix_en", {7'b0, pix_en}, 8'h00);
    check("R1 pix_color", {4'b0, pix_color}, {4'b0, BLANK});
    check("R1 modes", {5'b0, mode_biscan, mode_solid, mode_window}, 8'h00);

    // R4 display off before any config
    px("R4 disp off", 1, 4'h3, 0, 1, 4'h5, 0, 9'h000, 1);
    // R2 write not visible until vsync
    wr(8'h04);
    px("R2 held before vsync", 1, 4'h3, 0, 0, 4'h5, 0, 9'h000, 1);
    vs_pulse();
    // R5 OR, R12 latency through scoreboard
    px("R5 or both dots", 1, 4'h3, 0, 1, 4'h5, 0, 9'h000, 1);
    px("R5 or dot plus bg", 1, 4'h8, 0, 0, 4'h1, 1, 9'h000, 1);
    px("R12 next pixel", 0, 4'h3, 1, 0, 4'h5, 0, 9'h000, 1);
    // R11 precedence
    px("R11 nothing blank", 0, 4'h3, 0, 0, 4'h5, 0, 9'h000, 1);
    px("R11 border over bg", 0, 4'h3, 1, 0, 4'h5, 0, 9'h100, 1);
    px("R11 dot over border", 1, 4'h2, 0, 0, 4'h5, 0, 9'h100, 1);
    // R8 full border at each position
    for (int i = 0; i < 9; i++)
      px("R8 full border pos", 0, 4'h1, 0, 0, 4'h2, 0, 9'(1 << i), 1);
    // R6 layer 1 priority (mid-frame write stays inactive: R2)
    wr(8'h05);
    px("R2 mid-frame write ignored", 1, 4'h3, 0, 1, 4'h5, 0, 9'h000, 1);
    vs_pulse();
    px("R6 l1 first", 1, 4'h3, 0, 1, 4'h5, 0, 9'h000, 1);
    px("R6 l2 fallback", 0, 4'h3, 0, 1, 4'h5, 0, 9'h000, 1);
    // R7 layer 2 priority
    wr(8'h06); vs_pulse();
    px("R7 l2 first", 1, 4'h3, 0, 1, 4'h5, 0, 9'h000, 1);
    px("R7 l1 fallback", 1, 4'h3, 0, 0, 4'h5, 0, 9'h000, 1);
    // R5 reserved code
    wr(8'h07); vs_pulse();
    px("R5 reserved as or", 1, 4'h3, 0, 1, 4'h5, 0, 9'h000, 1);
    // R9 shadow border
    wr(8'h0C); vs_pulse();
    for (int i = 0; i < 9; i++)
      px("R9 shadow border pos", 0, 4'h1, 0, 0, 4'h2, 0, 9'(1 << i), 1);
    // R10 flash
    wr(8'h14); vs_pulse();
    px("R10 bg hidden off phase", 0, 4'h6, 1, 0, 4'h5, 0, 9'h000, 0);
    px("R10 dot kept off phase", 1, 4'h6, 0, 0, 4'h1, 1, 9'h000, 0);
    px("R10 bg shown on phase", 0, 4'h6, 1, 0, 4'h5, 0, 9'h000, 1);
    wr(8'h04); vs_pulse();
    px("R10 no flash when disabled", 0, 4'h6, 1, 0, 4'h5, 0, 9'h000, 0);
    // R2 write on the edge clock goes to the next edge; R13 modes, R3 layout
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 8'hE5; vsync = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; vsync = 1'b0;
    m_active = m_shadow; m_shadow = 8'hE5;
    #1;
    check("R2 same-clock write waits", {5'b0, mode_biscan, mode_solid, mode_window}, 8'h00);
    px("R2 same-clock write waits mix", 1, 4'h3, 0, 1, 4'h5, 0, 9'h000, 1);
    vs_pulse();
    #1;
    check("R13 modes follow active", {5'b0, mode_biscan, mode_solid, mode_window}, 8'h07);
    px("R3 field layout l1 first", 1, 4'h3, 0, 1, 4'h5, 0, 9'h000, 1);
    // R4 turn display off again
    wr(8'h01); vs_pulse();
    px("R4 disp cleared", 1, 4'h3, 1, 1, 4'h5, 1, 9'h1FF, 1);
    #1;
    check("R13 modes cleared", {5'b0, mode_biscan, mode_solid, mode_window}, 8'h00);
    repeat (3) @(posedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule